// File: doc/BRIEF.md
# Serial Transmitter with Room-Available Status

This block sends bytes on an asynchronous serial line. Each byte goes out as one frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The line rests high between frames. A host writes bytes with a one-cycle strobe and a data byte. Each written byte enters an eight-entry queue that sits in front of a frame shift register. A 16-bit divisor sets the bit period, so 9600, 19200 and 115200 baud can all be derived from one system clock.

The ready status is high whenever the queue has a free slot. It does not mean that the queue is empty. A host that checks ready once and then writes a burst can therefore overrun the queue. The block drops such writes without any handshake and records the loss in a sticky overflow flag, which a separate strobe clears. A second status output reports that all transmission has finished: the queue is empty and the last stop bit has completed. The interrupt output is a level signal equal to ready gated by an enable input, so it comes back after each byte that leaves a full queue.

Top module: `roomflag_uart_tx`

## Requirements
- R1: The queue holds 8 bytes in addition to the byte in the shift register. `tx_ready` is 1 while fewer than 8 bytes are queued, including while bytes are waiting, and 0 when 8 are queued.
- R2: A write made in a cycle where `tx_ready` is 0 is discarded and the queue contents are unchanged. With 7 bytes queued and the shifter busy, a burst of 8 writes keeps only the first byte.
- R3: Each frame drives `tx_out` low for the start bit, then the 8 data bits LSB first, then high for the stop bit. `tx_out` is 1 when no frame is in progress.
- R4: Every bit of a frame lasts exactly `divisor`+1 clock cycles. The divisor is 16 bits wide.
- R5: `tx_idle` is 1 only when the queue is empty and no frame is in progress, including its stop bit.
- R6: `irq` is a level output equal to `irq_en` AND `tx_ready`.
- R7: `ovf_flag` becomes 1 after any discarded write and stays 1 until a cycle with `ovf_clr` high and no discarded write. When a discarded write and `ovf_clr` fall in the same cycle, the flag sets.
- R8: If bytes are queued when a stop bit ends, the next start bit begins in the very next cycle, with no idle gap. A byte written to a fully idle block, accepted at clock edge k, drives `tx_out` low from edge k+1.
- R9: `rst` is synchronous and active high. It empties the queue, stops any frame, drives `tx_out` high and clears `ovf_flag`, so after reset `tx_ready`=1, `tx_idle`=1 and `ovf_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe for `wr_data` |
| wr_data | input | 8 | Byte to queue |
| divisor | input | 16 | Bit period minus one, in clock cycles |
| irq_en | input | 1 | Interrupt enable |
| ovf_clr | input | 1 | Clears the overflow flag |
| tx_out | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Queue has at least one free slot |
| tx_idle | output | 1 | Queue empty and no frame in progress |
| ovf_flag | output | 1 | Sticky: a write was dropped |
| irq | output | 1 | Level interrupt, enable AND ready |

## Verification
The bench fills the queue behind a busy shifter and then writes a burst of eight bytes. A design that treated ready as queue-empty, or that accepted a byte into a full queue, would either hold ready low with free space or send extra bytes on the line. The bench also sends back-to-back frames at a divisor of zero and of twelve. A design that left a spare idle cycle between frames, or that miscounted the bit period by one, would drift from the reference line waveform within a single frame. Two further cases are a clear strobe that collides with a dropped write, which catches clear-over-set priority, and a reset in the middle of a frame, which catches any leftover queue or shifter state.

// File: rtl/roomflag_pkg.sv
package roomflag_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned QUEUE_LEN  = 8;
    localparam int unsigned DIV_W      = 16;
    localparam int unsigned FRAME_BITS = BYTE_W + 2;
endpackage

// File: rtl/rf_tx_fifo.sv
module rf_tx_fifo #(
    parameter int unsigned W     = roomflag_pkg::BYTE_W,
    parameter int unsigned DEPTH = roomflag_pkg::QUEUE_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_req,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic         clr_ovf,
    output logic [W-1:0] head_data,
    output logic         not_full,
    output logic         not_empty,
    output logic         ovf
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr_ptr;
        logic [PTR_W-1:0]        rd_ptr;
        logic [CNT_W-1:0]        count;
        logic                    ovf;
    } fifo_state_t;

    fifo_state_t s_q, s_d;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    logic accept, pop_ok;

    always_comb begin
        s_d    = s_q;
        accept = push_req && (s_q.count != FULL_CNT);
        pop_ok = pop && (s_q.count != '0);
        if (pop_ok) begin
            s_d.rd_ptr = ptr_next(s_q.rd_ptr);
        end
        if (accept) begin
            s_d.mem[s_q.wr_ptr] = push_data;
            s_d.wr_ptr          = ptr_next(s_q.wr_ptr);
        end
        s_d.count = s_q.count + CNT_W'(accept) - CNT_W'(pop_ok);
        if (push_req && !accept) begin
            s_d.ovf = 1'b1;
        end else if (clr_ovf) begin
            s_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign head_data = s_q.mem[s_q.rd_ptr];
    assign not_full  = (s_q.count != FULL_CNT);
    assign not_empty = (s_q.count != '0);
    assign ovf       = s_q.ovf;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        s_q.count <= FULL_CNT); // R1

    AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (push_req && !not_full && !pop) |=> $stable(s_q.count)); // R2

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (s_q.ovf && !clr_ovf) |=> s_q.ovf); // R7
endmodule

// File: rtl/rf_tx_shifter.sv
module rf_tx_shifter #(
    parameter int unsigned W     = roomflag_pkg::BYTE_W,
    parameter int unsigned DIV_W = roomflag_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic             have_data,
    input  logic [W-1:0]     load_data,
    output logic             take,
    output logic             line,
    output logic             busy
);
    localparam int unsigned FRAME = W + 2;
    localparam int unsigned IDX_W = $clog2(FRAME);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME - 1);

    typedef struct packed {
        logic             busy;
        logic [FRAME-1:0] frame;
        logic [IDX_W-1:0] bit_idx;
        logic [DIV_W-1:0] tmr;
    } shift_state_t;

    shift_state_t s_q, s_d;

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        if (s_q.busy) begin
            if (s_q.tmr == divisor) begin
                s_d.tmr = '0;
                if (s_q.bit_idx == LAST_IDX) begin
                    if (have_data) begin
                        take        = 1'b1;
                        s_d.frame   = {1'b1, load_data, 1'b0};
                        s_d.bit_idx = '0;
                    end else begin
                        s_d.busy = 1'b0;
                    end
                end else begin
                    s_d.bit_idx = s_q.bit_idx + IDX_W'(1);
                    s_d.frame   = {1'b1, s_q.frame[FRAME-1:1]};
                end
            end else begin
                s_d.tmr = s_q.tmr + DIV_W'(1);
            end
        end else if (have_data) begin
            take        = 1'b1;
            s_d.busy    = 1'b1;
            s_d.frame   = {1'b1, load_data, 1'b0};
            s_d.bit_idx = '0;
            s_d.tmr     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign line = s_q.busy ? s_q.frame[0] : 1'b1;
    assign busy = s_q.busy;

    AST_START_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        take |=> (busy && !line)); // R8

    AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (s_q.busy && s_q.bit_idx == LAST_IDX) |-> line); // R3
endmodule

// File: rtl/roomflag_uart_tx.sv
module roomflag_uart_tx #(
    parameter int unsigned W     = roomflag_pkg::BYTE_W,
    parameter int unsigned DEPTH = roomflag_pkg::QUEUE_LEN,
    parameter int unsigned DIV_W = roomflag_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic [DIV_W-1:0] divisor,
    input  logic             irq_en,
    input  logic             ovf_clr,
    output logic             tx_out,
    output logic             tx_ready,
    output logic             tx_idle,
    output logic             ovf_flag,
    output logic             irq
);
    logic [W-1:0] head_data;
    logic         not_full, not_empty, take, sh_busy;

    rf_tx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_req  (wr_en),
        .push_data (wr_data),
        .pop       (take),
        .clr_ovf   (ovf_clr),
        .head_data (head_data),
        .not_full  (not_full),
        .not_empty (not_empty),
        .ovf       (ovf_flag)
    );

    rf_tx_shifter #(.W(W), .DIV_W(DIV_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .divisor   (divisor),
        .have_data (not_empty),
        .load_data (head_data),
        .take      (take),
        .line      (tx_out),
        .busy      (sh_busy)
    );

    assign tx_ready = not_full;
    assign tx_idle  = !sh_busy && !not_empty;
    assign irq      = irq_en && not_full;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> tx_out); // R5

    AST_IRQ_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
        irq |-> tx_ready); // R6
endmodule

// File: tb/tb_roomflag_uart_tx.sv
module tb_roomflag_uart_tx;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] divisor = 16'd3;
    logic        irq_en = 1'b0;
    logic        ovf_clr = 1'b0;
    logic        tx_out, tx_ready, tx_idle, ovf_flag, irq;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    roomflag_uart_tx dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .divisor(divisor), .irq_en(irq_en), .ovf_clr(ovf_clr),
        .tx_out(tx_out), .tx_ready(tx_ready), .tx_idle(tx_idle),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Behavioural reference
    byte unsigned mq[$];
    byte unsigned exp_q[$];
    byte unsigned rx_q[$];
    bit  m_busy = 0;
    int  m_bit = 0;
    int  m_tmr = 0;
    bit  m_ovf = 0;
    byte unsigned m_cur = 0;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete(); m_busy = 0; m_bit = 0; m_tmr = 0; m_ovf = 0;
        end else begin
            int  n_old;
            bit  full;
            n_old = mq.size();
            full  = (n_old == 8);
            if (m_busy) begin
                if (m_tmr == int'(divisor)) begin
                    m_tmr = 0;
                    if (m_bit == 9) begin
                        if (n_old > 0) begin
                            m_cur = mq.pop_front(); exp_q.push_back(m_cur); m_bit = 0;
                        end else m_busy = 0;
                    end else m_bit++;
                end else m_tmr++;
            end else if (n_old > 0) begin
                m_cur = mq.pop_front(); exp_q.push_back(m_cur);
                m_busy = 1; m_bit = 0; m_tmr = 0;
            end
            if (wr_en && !full) mq.push_back(wr_data);
            if (wr_en && full) m_ovf = 1;
            else if (ovf_clr)  m_ovf = 0;
        end
    end

    function automatic int model_line();
        if (!m_busy) return 1;
        if (m_bit == 0) return 0;
        if (m_bit == 9) return 1;
        return int'(m_cur[m_bit-1]);
    endfunction

    // Per-cycle comparison plus independent line decoder
    int dc_st = 0, dc_cnt = 0, dc_k = 0;
    byte unsigned dc_sh = 0;

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            int rdy;
            int half;
            rdy = (mq.size() < 8) ? 1 : 0;
            check("R3 line", int'(tx_out), model_line());
            check("R1 ready", int'(tx_ready), rdy);
            check("R5 idle", int'(tx_idle), (!m_busy && mq.size() == 0) ? 1 : 0);
            check("R6 irq", int'(irq), (irq_en && rdy != 0) ? 1 : 0);
            check("R7 ovf", int'(ovf_flag), int'(m_ovf));
            half = (int'(divisor) + 1) / 2;
            if (dc_st == 0) begin
                if (tx_out == 1'b0) begin dc_st = 1; dc_cnt = 0; dc_k = 1; end
            end else begin
                dc_cnt++;
                if (dc_cnt == half + dc_k * (int'(divisor) + 1)) begin
                    if (dc_k <= 8) dc_sh[dc_k-1] = tx_out;
                    else begin
                        check("R3 stop bit", int'(tx_out), 1);
                        rx_q.push_back(dc_sh);
                        dc_st = 0;
                    end
                    dc_k++;
                end
            end
        end else dc_st = 0;
    end

    task automatic put(input byte unsigned b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
    endtask

    task automatic release_bus();
        @(negedge clk); wr_en = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic wait_idle();
        do begin @(negedge clk); #2; end while (!tx_idle || dc_st != 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_rx(input string req);
        check({req, " byte count"}, rx_q.size(), exp_q.size());
        while (exp_q.size() > 0 && rx_q.size() > 0) begin
            check({req, " byte value"}, int'(rx_q.pop_front()), int'(exp_q.pop_front()));
        end
        rx_q.delete(); exp_q.delete();
    endtask

    task automatic measure_start(input string req, input int exp_len);
        int len;
        len = 0;
        do begin @(negedge clk); #2; end while (tx_out != 1'b0);
        while (tx_out == 1'b0) begin len++; @(negedge clk); #2; end
        check(req, len, exp_len);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R9 reset state
        check("R9 tx_out", int'(tx_out), 1);
        check("R9 ready", int'(tx_ready), 1);
        check("R9 idle", int'(tx_idle), 1);
        check("R9 ovf", int'(ovf_flag), 0);

        // R8 start timing from idle, R4 bit length
        divisor = 16'd3; irq_en = 1'b1;
        put(8'hFF);
        release_bus(); #2;
        check("R8 line before load", int'(tx_out), 1);
        check("R5 idle with queued byte", int'(tx_idle), 0);
        @(negedge clk); #2;
        check("R8 start bit edge", int'(tx_out), 0);
        wait_idle();
        check_rx("R3 single");

        measure_start_setup: begin
            put(8'hFF); release_bus();
            measure_start("R4 start length div3", 4);
            wait_idle(); check_rx("R4 div3");
        end

        // R8 back to back at divisor 0
        divisor = 16'd0;
        put(8'h5A); put(8'h01); put(8'h80);
        release_bus();
        wait_idle();
        check_rx("R8 back-to-back");

        // R1/R2/R7 overflow burst at divisor 12
        divisor = 16'd12;
        put(8'hC3); release_bus(); @(negedge clk);
        for (int i = 0; i < 7; i++) put(8'(8'h10 + i));
        release_bus(); #2;
        check("R1 ready with 7 queued", int'(tx_ready), 1);
        for (int i = 0; i < 8; i++) put(8'(8'h40 + i));
        release_bus(); #2;
        check("R1 ready when full", int'(tx_ready), 0);
        check("R2 ovf after burst", int'(ovf_flag), 1);
        check("R6 irq when full", int'(irq), 0);
        // clear colliding with a dropped write: set wins
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hEE; ovf_clr = 1'b1;
        release_bus(); #2;
        check("R7 set wins over clear", int'(ovf_flag), 1);
        @(negedge clk); ovf_clr = 1'b1;
        release_bus(); #2;
        check("R7 cleared", int'(ovf_flag), 0);
        wait_idle();
        check_rx("R2 burst keeps first");
        irq_en = 1'b0; #2;
        check("R6 irq masked", int'(irq), 0);
        irq_en = 1'b1; #2;
        check("R6 irq enabled", int'(irq), 1);

        // R4 at a realistic divisor
        divisor = 16'd433;
        put(8'hFF); release_bus();
        measure_start("R4 start length div433", 434);
        wait_idle(); check_rx("R4 div433");

        // R9 reset in the middle of a frame
        divisor = 16'd5;
        put(8'h33); put(8'h44); put(8'h55); release_bus();
        repeat (20) @(negedge clk);
        rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0; #2;
        check("R9 mid reset line", int'(tx_out), 1);
        check("R9 mid reset idle", int'(tx_idle), 1);
        check("R9 mid reset ready", int'(tx_ready), 1);
        repeat (100) @(negedge clk); #2;
        check("R9 nothing sent after reset", int'(tx_out), 1);
        rx_q.delete(); exp_q.delete();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule